// File: doc/BRIEF.md
# Rounding, Saturating and Formatting Output Stage

This block sits between a filter's wide accumulator and a 16-bit output bus. Each time the owner strobes it, the block takes the signed internal result and rounds it to a kept width between 8 and 16 bits. The kept width is chosen at run time by a 3-bit select. The block never truncates. Rounding adds half of the kept LSB's weight, and every output bit below the kept width reads zero.

When the rounded value does not fit in 16 signed bits, the block clamps it to the matching full-scale word. That check is made after the rounding add, so a carry caused by rounding also clamps. A format select then keeps the word as two's complement or recodes it as inverted offset binary. The coded word is held in an output register. That register drives the bus through a three-state gate whose enable acts at once, with no dependence on the clock.

The accumulator input carries `GUARD_W` bits above the 16-bit output field and `FRAC_W` fraction bits below it. The output LSB therefore has weight 2^FRAC_W in accumulator units.

Top module: `rnd_sat_out`

## Requirements
- R1: The stored value is floor((A + 2^(D-1)) / 2^D) scaled back by 2^(16-K). Here A is the signed accumulator input, K is the kept width and D = FRAC_W + 16 - K. An exact half step therefore rounds upward, toward positive infinity.
- R2: The select `rnd_sel` maps codes 0 through 6 to kept widths 8 through 14, and code 7 to a kept width of 16.
- R3: In two's complement coding, the 16-K bits below the kept width are zero whenever the result has not clamped.
- R4: A rounded result above 32767 output units stores 0x7FFF. This includes a result that only overflows because of the rounding carry.
- R5: A rounded result below -32768 output units stores 0x8000.
- R6: With `fmt_sel` = 1, the stored word is the two's complement word with bits 14..0 inverted and bit 15 unchanged. This is applied after clamping, so the clamp words become 0x0000 and 0xFFFF. With `fmt_sel` = 0, the word is plain two's complement.
- R7: The output register loads only on a rising clock edge where `ld_en` is 1. On every other edge it holds its value, whatever the other inputs do.
- R8: A synchronous active-high `rst` clears the output register to 0x0000.
- R9: When `drive_en` is 0, `dout` is high impedance. When `drive_en` is 1, `dout` shows the output register. Both follow `drive_en` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe for the output register |
| acc_in | input | GUARD_W+16+FRAC_W | Signed internal result from the accumulator |
| rnd_sel | input | 3 | Kept-width code (0..6 gives 8..14 bits, 7 gives 16 bits) |
| fmt_sel | input | 1 | 0 selects two's complement, 1 selects inverted offset binary |
| drive_en | input | 1 | Asynchronous three-state enable for `dout` |
| dout | output | 16 | Three-state output bus |

## Verification
The bench builds the block with its defaults: four guard bits and two fraction bits, which makes a 22-bit accumulator input. The two fraction bits give the 16-bit width a real half step, so rounding at full width and the round-up of ties can be seen. The four guard bits allow inputs up to sixteen times full scale in either sign. This brings both clamp directions within reach, along with the case where the clamp is caused only by the rounding carry. A pull-up on the bench side of the bus shows when the block has released `dout`.

// File: rtl/rso_pkg.sv
package rso_pkg;

    localparam int OUT_W = 16;
    localparam int SEL_W = 3;
    localparam int NUM_SEL = 1 << SEL_W;

    typedef enum logic {
        FMT_TWOS       = 1'b0,
        FMT_OFFSET_INV = 1'b1
    } fmt_e;

    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             clip_hi;
        logic             clip_lo;
    } lim_t;

    // kept output width for a select code: 8..14, top code gives full 16
    function automatic int keep_bits(input logic [SEL_W-1:0] sel);
        if (sel == SEL_W'(NUM_SEL - 1)) begin
            return OUT_W;
        end
        return 8 + int'(sel);
    endfunction

    // output bits cleared below the kept width
    function automatic int cut_bits(input logic [SEL_W-1:0] sel);
        return OUT_W - keep_bits(sel);
    endfunction

endpackage

// File: rtl/rso_round.sv
module rso_round
    import rso_pkg::*;
#(
    parameter int GUARD_W = 4,
    parameter int FRAC_W  = 2,
    localparam int ACC_W  = GUARD_W + OUT_W + FRAC_W,
    localparam int SUM_W  = ACC_W + 1
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [SEL_W-1:0] rnd_sel,
    output logic [SUM_W-1:0] sum_out
);

    logic [SUM_W-1:0] half_tab [NUM_SEL];

    // half of the kept LSB weight, in accumulator units, per select code
    for (genvar c = 0; c < NUM_SEL; c++) begin : g_half
        assign half_tab[c] = SUM_W'(1) << (FRAC_W + cut_bits(SEL_W'(c)) - 1);
    end

    always_comb begin
        sum_out = {acc_in[ACC_W-1], acc_in} + half_tab[rnd_sel];
    end

endmodule

// File: rtl/rso_limit.sv
module rso_limit
    import rso_pkg::*;
#(
    parameter int GUARD_W = 4,
    parameter int FRAC_W  = 2,
    localparam int ACC_W  = GUARD_W + OUT_W + FRAC_W,
    localparam int SUM_W  = ACC_W + 1,
    localparam int TOP_LO = FRAC_W + OUT_W - 1,
    localparam int TOP_W  = SUM_W - TOP_LO
) (
    input  logic [SUM_W-1:0] sum_in,
    input  logic [SEL_W-1:0] rnd_sel,
    output lim_t             lim_out
);

    localparam logic [OUT_W-1:0] FULL_POS = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] FULL_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic [OUT_W-1:0] keep_mask [NUM_SEL];
    logic [TOP_W-1:0] top_bits;
    logic             fits;
    logic [OUT_W-1:0] field;

    for (genvar c = 0; c < NUM_SEL; c++) begin : g_mask
        assign keep_mask[c] = ~((OUT_W'(1) << cut_bits(SEL_W'(c))) - OUT_W'(1));
    end

    always_comb begin
        // the output sign bit and every guard bit must agree for a fit
        top_bits        = sum_in[SUM_W-1:TOP_LO];
        fits            = (&top_bits) | (~|top_bits);
        field           = sum_in[FRAC_W+OUT_W-1:FRAC_W];
        lim_out.clip_hi = !fits && !sum_in[SUM_W-1];
        lim_out.clip_lo = !fits &&  sum_in[SUM_W-1];
        if (lim_out.clip_hi) begin
            lim_out.word = FULL_POS;
        end else if (lim_out.clip_lo) begin
            lim_out.word = FULL_NEG;
        end else begin
            lim_out.word = field & keep_mask[rnd_sel];
        end
    end

endmodule

// File: rtl/rso_encode.sv
module rso_encode
    import rso_pkg::*;
(
    input  lim_t             lim_in,
    input  fmt_e             fmt,
    output logic [OUT_W-1:0] word_out
);

    logic flip;

    assign flip = (fmt == FMT_OFFSET_INV);

    for (genvar b = 0; b < OUT_W; b++) begin : g_bit
        if (b == OUT_W - 1) begin : g_sign
            assign word_out[b] = lim_in.word[b];
        end else begin : g_mag
            assign word_out[b] = lim_in.word[b] ^ flip;
        end
    end

endmodule

// File: rtl/rnd_sat_out.sv
module rnd_sat_out
    import rso_pkg::*;
#(
    parameter int GUARD_W = 4,
    parameter int FRAC_W  = 2,
    localparam int ACC_W  = GUARD_W + OUT_W + FRAC_W,
    localparam int SUM_W  = ACC_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [SEL_W-1:0] rnd_sel,
    input  logic             fmt_sel,
    input  logic             drive_en,
    output wire  [OUT_W-1:0] dout
);

    logic [SUM_W-1:0] rounded;
    lim_t             limited;
    logic [OUT_W-1:0] coded;
    logic [OUT_W-1:0] out_q;
    fmt_e             fmt;

    assign fmt = fmt_e'(fmt_sel);

    rso_round #(
        .GUARD_W (GUARD_W),
        .FRAC_W  (FRAC_W)
    ) u_round (
        .acc_in  (acc_in),
        .rnd_sel (rnd_sel),
        .sum_out (rounded)
    );

    rso_limit #(
        .GUARD_W (GUARD_W),
        .FRAC_W  (FRAC_W)
    ) u_limit (
        .sum_in  (rounded),
        .rnd_sel (rnd_sel),
        .lim_out (limited)
    );

    rso_encode u_encode (
        .lim_in   (limited),
        .fmt      (fmt),
        .word_out (coded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (ld_en) begin
            out_q <= coded;
        end
    end

    assign dout = drive_en ? out_q : {OUT_W{1'bz}};

endmodule

// File: rtl/rso_checker.sv
module rso_checker
    import rso_pkg::*;
#(
    parameter int GUARD_W = 4,
    parameter int FRAC_W  = 2,
    localparam int ACC_W  = GUARD_W + OUT_W + FRAC_W
) (
    input logic             clk,
    input logic             rst,
    input logic             ld_en,
    input logic [ACC_W-1:0] acc_in,
    input logic [SEL_W-1:0] rnd_sel,
    input logic             fmt_sel,
    input logic             drive_en,
    input logic [OUT_W-1:0] dout,
    input logic [OUT_W-1:0] out_q
);

    logic big_pos;
    logic big_neg;

    // well past full scale, so no rounding add can pull the value back in
    assign big_pos = !acc_in[ACC_W-1] && (acc_in[ACC_W-2:FRAC_W+OUT_W-1] != '0);
    assign big_neg =  acc_in[ACC_W-1] && (acc_in[ACC_W-2:FRAC_W+OUT_W] != '1);

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (out_q == '0)); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ld_en |=> $stable(out_q)); // R7

    AST_LOW_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !fmt_sel && rnd_sel == '0) |=>
        (out_q[7:0] == 8'h00 || out_q == 16'h7FFF)); // R3

    AST_CLIP_POS: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !fmt_sel && big_pos) |=> (out_q == 16'h7FFF)); // R4

    AST_CLIP_NEG: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !fmt_sel && big_neg) |=> (out_q == 16'h8000)); // R5

    always_comb begin
        if (drive_en) begin
            AST_BUS_FOLLOWS: assert (dout == out_q); // R9
        end
    end

endmodule

bind rnd_sat_out rso_checker #(
    .GUARD_W (GUARD_W),
    .FRAC_W  (FRAC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_en),
    .acc_in   (acc_in),
    .rnd_sel  (rnd_sel),
    .fmt_sel  (fmt_sel),
    .drive_en (drive_en),
    .dout     (dout),
    .out_q    (out_q)
);

// File: tb/rnd_sat_out_test.sv
`timescale 1ns/1ps
module rnd_sat_out_test;

    localparam int GW    = 4;
    localparam int FW    = 2;
    localparam int AW    = GW + 16 + FW;
    localparam int LIMIT = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic [AW-1:0] acc_in = '0;
    logic [2:0]    rnd_sel = 3'd7;
    logic          fmt_sel = 1'b0;
    logic          drive_en = 1'b1;
    wire  [15:0]   dout_bus;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    for (genvar i = 0; i < 16; i++) begin : g_pu
        pullup pu (dout_bus[i]);
    end

    rnd_sat_out #(.GUARD_W(GW), .FRAC_W(FW)) uut (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ld_en),
        .acc_in   (acc_in),
        .rnd_sel  (rnd_sel),
        .fmt_sel  (fmt_sel),
        .drive_en (drive_en),
        .dout     (dout_bus)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] model(input longint acc, input int sel, input bit fmt);
        int          keep;
        int          drop;
        longint      s;
        longint      q;
        logic [15:0] w;
        keep = (sel == 7) ? 16 : 8 + sel;
        drop = FW + 16 - keep;
        s = acc + (64'sd1 <<< (drop - 1));
        q = (s >>> drop) <<< (16 - keep);
        if (q > 32767) w = 16'h7FFF;
        else if (q < -32768) w = 16'h8000;
        else w = q[15:0];
        if (fmt) w = w ^ 16'h7FFF;
        return w;
    endfunction

    // one loaded sample; result readable at the following falling edge
    task automatic load(input longint acc, input int sel, input bit fmt);
        @(negedge clk);
        acc_in  = AW'(acc);
        rnd_sel = 3'(sel);
        fmt_sel = fmt;
        ld_en   = 1'b1;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    task automatic t_reset();
        drive_en = 1'b1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 reset state", dout_bus, 16'h0000);
        rst = 1'b0;
        load(64'sd4660 * 4, 7, 1'b0);
        check("R1 load before reset", dout_bus, 16'h1234);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 reset clears", dout_bus, 16'h0000);
    endtask

    task automatic t_widths();
        longint vals [4] = '{64'sd74565, -64'sd74565, 64'sd1000003, -64'sd777777};
        // hand-derived values at full width, two fraction bits
        load(6, 7, 1'b0);  check("R1 1.5 rounds up", dout_bus, 16'h0002);
        load(5, 7, 1'b0);  check("R1 1.25 rounds down", dout_bus, 16'h0001);
        load(-6, 7, 1'b0); check("R1 -1.5 rounds up", dout_bus, 16'hFFFF);
        load(-1, 7, 1'b0); check("R1 -0.25 rounds to zero", dout_bus, 16'h0000);
        // code 0 keeps 8 bits: 0x12C0 + half of 0x100 rounds to 0x1300
        load(64'sd4800 * 4, 0, 1'b0); check("R2 code 0 keeps 8", dout_bus, 16'h1300);
        load(64'sd4800 * 4, 6, 1'b0); check("R2 code 6 keeps 14", dout_bus, 16'h12C0);
        for (int sel = 0; sel < 8; sel++) begin
            int keep;
            int drop;
            longint tie;
            keep = (sel == 7) ? 16 : 8 + sel;
            drop = FW + 16 - keep;
            for (int k = 0; k < 4; k++) begin
                load(vals[k], sel, 1'b0);
                check("R1 R2 width sweep", dout_bus, model(vals[k], sel, 1'b0));
            end
            tie = (64'sd3 <<< drop) + (64'sd1 <<< (drop - 1));
            load(tie, sel, 1'b0);
            check("R1 tie rounds up", dout_bus, 16'(64'sd4 <<< (16 - keep)));
            if (keep < 16) begin
                load(64'sd32767, sel, 1'b0);
                check("R3 low bits zero", dout_bus & 16'((1 << (16 - keep)) - 1), 16'h0000);
            end
        end
    endtask

    task automatic t_sat_pos();
        load((64'sd1 <<< (AW - 1)) - 1, 7, 1'b0);
        check("R4 max input", dout_bus, 16'h7FFF);
        load(64'sd32512 * 4, 0, 1'b0);
        check("R4 in range at 8 bits", dout_bus, 16'h7F00);
        load(64'sd32767 * 4, 0, 1'b0);
        check("R4 rounding carry clamps", dout_bus, 16'h7FFF);
        load(64'sd32767 * 4 + 2, 7, 1'b0);
        check("R4 carry at 16 bits", dout_bus, 16'h7FFF);
    endtask

    task automatic t_sat_neg();
        load(-(64'sd1 <<< (AW - 1)), 7, 1'b0);
        check("R5 min input", dout_bus, 16'h8000);
        load(-64'sd32768 * 4 - 3, 7, 1'b0);
        check("R5 just below", dout_bus, 16'h8000);
        load(-64'sd32768 * 4, 7, 1'b0);
        check("R5 exact minimum", dout_bus, 16'h8000);
        load(-64'sd40000 * 4, 3, 1'b0);
        check("R5 clamp at 11 bits", dout_bus, 16'h8000);
    endtask

    task automatic t_format();
        load(64'sd4660 * 4, 7, 1'b1);
        check("R6 offset coding", dout_bus, 16'h6DCB);
        load(64'sd4660 * 4, 7, 1'b0);
        check("R6 plain coding", dout_bus, 16'h1234);
        load(64'sd1 <<< 20, 7, 1'b1);
        check("R6 positive clamp coded", dout_bus, 16'h0000);
        load(-(64'sd1 <<< 20), 7, 1'b1);
        check("R6 negative clamp coded", dout_bus, 16'hFFFF);
        load(-64'sd1000 * 4, 2, 1'b1);
        check("R6 negative coded", dout_bus, model(-64'sd4000, 2, 1'b1));
    endtask

    task automatic t_hold();
        load(64'sd2748 * 4, 7, 1'b0);
        check("R7 loaded", dout_bus, 16'h0ABC);
        acc_in  = AW'(-64'sd99999);
        rnd_sel = 3'd0;
        fmt_sel = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 hold without strobe", dout_bus, 16'h0ABC);
        fmt_sel = 1'b0;
    endtask

    task automatic t_tristate();
        @(negedge clk);
        #0.5;
        drive_en = 1'b0;
        #0.5;
        check("R9 released bus", dout_bus, 16'hFFFF);
        drive_en = 1'b1;
        #0.5;
        check("R9 driven again", dout_bus, 16'h0ABC);
    endtask

    initial begin
        t_reset();
        t_widths();
        t_sat_pos();
        t_sat_neg();
        t_format();
        t_hold();
        t_tristate();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule